// File: doc/BRIEF.md
# Output Audio Stream Control and Link Position Tracker

This block holds the control and status state of one outgoing audio DMA stream. Software sets a stream reset, a run request, a DMA hold and three interrupt enables through a small register port. It reads back a control word that shows what the hardware is actually doing, not only what was last written. The stream reset is a handshake in both directions. Asserting it drains the stream state over a fixed number of cycles before the reset bit reads 1. Releasing it takes the same number of cycles before the bit reads 0 again. A run request that is withdrawn keeps reading as running until the attached DMA engine reports that it has stopped.

Three stream events set sticky status flags: a buffer completing with its interrupt-on-completion marker, a FIFO underrun and a descriptor error. Each flag reaches the interrupt line only when its enable is set. A byte counter follows how far playback has got through a cyclic buffer. It adds the byte counts reported by the link while the stream is active and folds back to zero at a programmable buffer length. The block also gives the DMA side an enable, a one-cycle cadence-restart pulse and a flush signal that is held for as long as the stream is in reset.

Top module: `stream_ctl_top`

## Requirements
- R1: After the synchronous active-low reset, all four registers read 0, and `irq`, `dma_en`, `cad_rst` and `fifo_flush` are 0. The registers are: control at address 0, status at 1, position at 2 and buffer length at 3.
- R2: A control write with bit 0 set, made while control bit 1 reads 0 and the stream is out of reset, does three things at that clock edge. It clears the run request, the hold bit, the enables, the status bits, the length and the position. It raises `fifo_flush` from the next cycle. Control bit 0 reads 1 only after exactly 4 further clock edges.
- R3: While the stream is in reset, the only write with any effect is a control write with bit 0 clear, and only once bit 0 reads 1. That write starts the exit: bit 0 keeps reading 1 for 4 more edges, and after that bit 0 and `fifo_flush` fall together. Writes to other bits or registers, and stream events, change nothing during reset.
- R4: A control write with bit 0 set, made while control bit 1 reads 1, does not start a reset. It sets status bit 5. The other bits of that write take effect as usual.
- R5: `dma_en` is 1 exactly when the run request (control bit 1 as last written) is 1, the hold bit (control bit 5) is 0 and the stream is out of reset.
- R6: Control bit 1 reads 1 from the edge where run is written 1. After run is written 0, it keeps reading 1 until an edge where `dma_stopped` is sampled high.
- R7: A control write that changes the run request from 0 to 1 gives a `cad_rst` pulse of exactly one cycle, starting right after that edge. The same write clears the position to 0.
- R8: The status flags are bit 2 (buffer complete with completion marker), bit 3 (FIFO underrun) and bit 4 (descriptor error). Each is set by its event input and cleared by writing 1 to its position at address 1. An event in the same cycle as the clear wins.
- R9: `irq` is the OR of status bits 2, 3 and 4, each ANDed with the enable at the same control bit position. Status bit 5 never drives `irq`.
- R10: In each cycle where `dma_en` and `bytes_valid` are both 1, the position becomes position + `bytes`. If that sum is at least the length, the length is subtracted, so the position stays below the length when `bytes` is at most the length. A length of 0 holds the position at 0. In other cycles the position does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data for rd_addr, combinational |
| ev_ioc | input | 1 | Buffer completed with completion marker set |
| ev_underrun | input | 1 | FIFO underrun, samples dropped |
| ev_desc_err | input | 1 | Descriptor error |
| bytes_valid | input | 1 | Link reports bytes sent this cycle |
| bytes | input | 16 | Byte count sent this cycle |
| dma_stopped | input | 1 | DMA engine is idle |
| dma_en | output | 1 | DMA engine enable |
| cad_rst | output | 1 | Cadence generator restart pulse |
| fifo_flush | output | 1 | Stream FIFO held in reset |
| irq | output | 1 | Stream interrupt |

## Verification
A behavioural model in the bench runs in lockstep with the design. Every cycle it compares all four registers and all outputs against the model. Byte counts of 30 against a length of 100 test whether the counter folds back rather than saturating. A sum that lands exactly on the length tests whether the fold uses "at least" rather than "greater than". A length of 0 exercises the counter's hold case. Several stimulus patterns each separate one pair of behaviours:
- Events are raised once with the enable set and once with it clear, which separates the sticky flag from the interrupt gating.
- An event is raised in the same cycle as a write-1-to-clear, which shows which of the two wins.
- A reset is requested while running and again after stopping, which separates a refused reset from a real one.
- Run is withdrawn with `dma_stopped` low and then high, which shows that the readback waits for the engine rather than echoing the written value.

// File: rtl/stream_ctl_pkg.sv
// Shared types and register layout for the stream control block.
package stream_ctl_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ENTER = 2'd1,
        SEQ_HOLD  = 2'd2,
        SEQ_EXIT  = 2'd3
    } seq_state_e;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_STAT = 2'd1;
    localparam logic [1:0] REG_POS  = 2'd2;
    localparam logic [1:0] REG_LEN  = 2'd3;

    localparam int CB_RST  = 0;
    localparam int CB_RUN  = 1;
    localparam int CB_EN0  = 2;   // first of three enable bits (2..4)
    localparam int CB_HOLD = 5;
    localparam int SB_LO   = 2;   // status flags occupy bits 2..5
    localparam int N_EV    = 3;
endpackage

// File: rtl/sc_reset_seq.sv
// Stream reset handshake sequencer.
// Enters reset on a reset request while the stream is idle and not running,
// spends SEQ_CYCLES edges before reporting "in reset", and spends the same
// number of edges on exit. Assumes SEQ_CYCLES >= 2.
module sc_reset_seq
    import stream_ctl_pkg::*;
#(
    parameter int SEQ_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr_i,
    input  logic rst_bit_i,
    input  logic run_busy_i,
    output logic start_o,
    output logic refused_o,
    output logic in_reset_o,
    output logic rst_rb_o
);
    localparam int CNT_W = $clog2(SEQ_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SEQ_CYCLES - 1);

    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;

    // Request decode: start only from idle with run released.
    always_comb begin
        start_o   = ctl_wr_i && rst_bit_i && (state_q == SEQ_IDLE) && !run_busy_i;
        refused_o = ctl_wr_i && rst_bit_i && (state_q == SEQ_IDLE) && run_busy_i;
    end

    assign in_reset_o = (state_q != SEQ_IDLE);
    assign rst_rb_o   = (state_q == SEQ_HOLD) || (state_q == SEQ_EXIT);

    // Sequence state and cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    cnt_q <= '0;
                    if (start_o) state_q <= SEQ_ENTER;
                end
                SEQ_ENTER: begin
                    if (cnt_q == LAST) begin
                        state_q <= SEQ_HOLD;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SEQ_HOLD: begin
                    cnt_q <= '0;
                    if (ctl_wr_i && !rst_bit_i) state_q <= SEQ_EXIT;
                end
                SEQ_EXIT: begin
                    if (cnt_q == LAST) begin
                        state_q <= SEQ_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assert_rb_from_enter_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_rb_o) |-> $past(state_q) == SEQ_ENTER);
    assert_rb_falls_to_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_rb_o) |-> !in_reset_o);
    assert_refuse_stays_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
        refused_o |=> !in_reset_o);
endmodule

// File: rtl/sc_ctl_regs.sv
// Control register bank with run/stop handshake.
// Holds run request, hold, interrupt enables and buffer length. Run readback
// stays set until the DMA engine reports idle. clear_i wipes everything.
module sc_ctl_regs
    import stream_ctl_pkg::*;
#(
    parameter int LEN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr_i,
    input  logic             len_wr_i,
    input  logic [31:0]      wdata_i,
    input  logic             clear_i,
    input  logic             in_reset_i,
    input  logic             dma_stopped_i,
    output logic             run_busy_o,
    output logic             hold_o,
    output logic [N_EV-1:0]  irq_en_o,
    output logic [LEN_W-1:0] len_o,
    output logic             dma_en_o,
    output logic             run_start_o,
    output logic             cad_rst_o
);
    logic run_q;
    logic run_d;

    // Next run request value and rising-request detect.
    always_comb begin
        run_d       = clear_i ? 1'b0 : (ctl_wr_i ? wdata_i[CB_RUN] : run_q);
        run_start_o = !clear_i && ctl_wr_i && wdata_i[CB_RUN] && !run_q;
    end

    // Control fields and length register.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            run_q    <= 1'b0;
            hold_o   <= 1'b0;
            irq_en_o <= '0;
            len_o    <= '0;
        end else begin
            run_q <= run_d;
            if (ctl_wr_i) begin
                hold_o   <= wdata_i[CB_HOLD];
                irq_en_o <= wdata_i[CB_EN0 +: N_EV];
            end
            if (len_wr_i) len_o <= wdata_i[LEN_W-1:0];
        end
    end

    // Run readback: follows request, lingers until the engine is idle.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) run_busy_o <= 1'b0;
        else                   run_busy_o <= run_d || (run_busy_o && !dma_stopped_i);
    end

    // One-cycle cadence restart on a new run.
    always_ff @(posedge clk) begin
        if (!rst_n) cad_rst_o <= 1'b0;
        else        cad_rst_o <= run_start_o;
    end

    assign dma_en_o = run_q && !hold_o && !in_reset_i;

    assert_en_implies_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dma_en_o |-> run_busy_o);
    assert_busy_waits_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_busy_o && !dma_stopped_i && !clear_i) |=> run_busy_o);
    assert_cad_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cad_rst_o |=> !cad_rst_o);
    assert_cad_with_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cad_rst_o |-> run_busy_o);
endmodule

// File: rtl/sc_status.sv
// Sticky status flags with write-1-to-clear and gated interrupt.
// Flags: [0] completion, [1] underrun, [2] descriptor error, [3] refused reset.
// A set in the same cycle as a clear wins; clear_i drops all events.
module sc_status
    import stream_ctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear_i,
    input  logic            st_wr_i,
    input  logic [3:0]      w1c_i,
    input  logic [N_EV-1:0] ev_i,
    input  logic            refused_i,
    input  logic [N_EV-1:0] irq_en_i,
    output logic [3:0]      st_o,
    output logic            irq_o
);
    logic [3:0] set_v;
    logic [3:0] clr_v;

    // Set and clear masks for this cycle.
    always_comb begin
        set_v = {refused_i, ev_i};
        clr_v = st_wr_i ? w1c_i : 4'b0;
    end

    // Flag register update.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) st_o <= '0;
        else                   st_o <= (st_o & ~clr_v) | set_v;
    end

    assign irq_o = |(st_o[N_EV-1:0] & irq_en_i);

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i[0] && !clear_i) |=> st_o[0]);
    assert_flag_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_o[N_EV-1:0] == '0) |-> !irq_o);
    assert_reset_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (st_o == '0));
endmodule

// File: rtl/sc_link_pos.sv
// Link position counter for a cyclic buffer.
// Adds the byte count each active cycle and folds back at the length.
// Assumes a single step never exceeds the length. Length 0 pins it at 0.
module sc_link_pos #(
    parameter int POS_W   = 32,
    parameter int BYTES_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               adv_i,
    input  logic [BYTES_W-1:0] bytes_i,
    input  logic [POS_W-1:0]   len_i,
    output logic [POS_W-1:0]   pos_o
);
    logic [POS_W:0]   sum;
    logic [POS_W-1:0] next_pos;

    // Wrapped next position.
    always_comb begin
        sum = {1'b0, pos_o} + {{(POS_W + 1 - BYTES_W){1'b0}}, bytes_i};
        if (len_i == '0)                 next_pos = '0;
        else if (sum >= {1'b0, len_i})   next_pos = POS_W'(sum - {1'b0, len_i});
        else                             next_pos = sum[POS_W-1:0];
    end

    // Position register.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) pos_o <= '0;
        else if (adv_i)        pos_o <= next_pos;
    end

    assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (pos_o == '0));
    assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !clear_i) |=> $stable(pos_o));
endmodule

// File: rtl/stream_ctl_top.sv
// Output audio stream control and link position tracker.
// Decodes the register port, ties the reset sequencer, control bank, status
// flags and position counter together, and muxes readback.
module stream_ctl_top
    import stream_ctl_pkg::*;
#(
    parameter int SEQ_CYCLES = 4,
    parameter int BYTES_W    = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [31:0]        wr_data,
    input  logic [1:0]         rd_addr,
    output logic [31:0]        rd_data,
    input  logic               ev_ioc,
    input  logic               ev_underrun,
    input  logic               ev_desc_err,
    input  logic               bytes_valid,
    input  logic [BYTES_W-1:0] bytes,
    input  logic               dma_stopped,
    output logic               dma_en,
    output logic               cad_rst,
    output logic               fifo_flush,
    output logic               irq
);
    localparam int POS_W = 32;

    logic            ctl_wr, st_wr, len_wr;
    logic            seq_start, seq_refused, in_reset, rst_rb, clear;
    logic            run_busy, hold, run_start;
    logic [N_EV-1:0] irq_en;
    logic [POS_W-1:0] len_q, pos_q;
    logic [3:0]      st_q;

    // Write decode.
    always_comb begin
        ctl_wr = wr_en && (wr_addr == REG_CTRL);
        st_wr  = wr_en && (wr_addr == REG_STAT);
        len_wr = wr_en && (wr_addr == REG_LEN);
    end

    assign clear      = seq_start || in_reset;
    assign fifo_flush = in_reset;

    sc_reset_seq #(.SEQ_CYCLES(SEQ_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr_i(ctl_wr), .rst_bit_i(wr_data[CB_RST]), .run_busy_i(run_busy),
        .start_o(seq_start), .refused_o(seq_refused),
        .in_reset_o(in_reset), .rst_rb_o(rst_rb)
    );

    sc_ctl_regs #(.LEN_W(POS_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr_i(ctl_wr), .len_wr_i(len_wr), .wdata_i(wr_data),
        .clear_i(clear), .in_reset_i(in_reset), .dma_stopped_i(dma_stopped),
        .run_busy_o(run_busy), .hold_o(hold), .irq_en_o(irq_en), .len_o(len_q),
        .dma_en_o(dma_en), .run_start_o(run_start), .cad_rst_o(cad_rst)
    );

    sc_status u_status (
        .clk(clk), .rst_n(rst_n), .clear_i(clear),
        .st_wr_i(st_wr), .w1c_i(wr_data[SB_LO +: 4]),
        .ev_i({ev_desc_err, ev_underrun, ev_ioc}), .refused_i(seq_refused),
        .irq_en_i(irq_en), .st_o(st_q), .irq_o(irq)
    );

    sc_link_pos #(.POS_W(POS_W), .BYTES_W(BYTES_W)) u_pos (
        .clk(clk), .rst_n(rst_n),
        .clear_i(clear || run_start), .adv_i(dma_en && bytes_valid),
        .bytes_i(bytes), .len_i(len_q), .pos_o(pos_q)
    );

    // Readback mux.
    always_comb begin
        unique case (rd_addr)
            REG_CTRL: rd_data = {26'b0, hold, irq_en, run_busy, rst_rb};
            REG_STAT: rd_data = {26'b0, st_q, 2'b00};
            REG_POS:  rd_data = pos_q;
            default:  rd_data = len_q;
        endcase
    end
endmodule

// File: tb/stream_ctl_top_tb_top.sv
`timescale 1ns/1ps
module stream_ctl_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic [1:0]  rd_addr = 2'd0;
    logic [31:0] rd_data;
    logic        ev_ioc = 1'b0, ev_underrun = 1'b0, ev_desc_err = 1'b0;
    logic        bytes_valid = 1'b0;
    logic [15:0] bytes = 16'd0;
    logic        dma_stopped = 1'b1;
    logic        dma_en, cad_rst, fifo_flush, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    stream_ctl_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ev_ioc(ev_ioc), .ev_underrun(ev_underrun), .ev_desc_err(ev_desc_err),
        .bytes_valid(bytes_valid), .bytes(bytes), .dma_stopped(dma_stopped),
        .dma_en(dma_en), .cad_rst(cad_rst), .fifo_flush(fifo_flush), .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    int          m_state;   // 0 out, 1 entering, 2 in reset, 3 leaving
    int          m_cnt;
    bit          m_run, m_hold, m_busy, m_cad;
    bit [2:0]    m_en;
    bit [3:0]    m_st;
    logic [31:0] m_len, m_pos;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_run = 0; m_hold = 0; m_busy = 0;
            m_cad = 0; m_en = 0; m_st = 0; m_len = 0; m_pos = 0;
        end else begin
            bit cw, sw, lw, start, refuse, clr, rd, rs, en_now;
            longint s;
            cw = wr_en && wr_addr == 2'd0;
            sw = wr_en && wr_addr == 2'd1;
            lw = wr_en && wr_addr == 2'd3;
            start  = cw && wr_data[0] && m_state == 0 && !m_busy;
            refuse = cw && wr_data[0] && m_state == 0 && m_busy;
            clr    = start || m_state != 0;
            en_now = m_run && !m_hold && m_state == 0;
            rd = clr ? 1'b0 : (cw ? wr_data[1] : m_run);
            rs = !clr && cw && wr_data[1] && !m_run;
            // position
            if (clr || rs) m_pos = 0;
            else if (en_now && bytes_valid) begin
                if (m_len == 0) m_pos = 0;
                else begin
                    s = longint'(m_pos) + longint'(bytes);
                    if (s >= longint'(m_len)) s = s - longint'(m_len);
                    m_pos = 32'(s);
                end
            end
            // status
            if (clr) m_st = 0;
            else m_st = (m_st & ~(sw ? wr_data[5:2] : 4'b0)) |
                        {refuse, ev_desc_err, ev_underrun, ev_ioc};
            // control
            m_busy = clr ? 1'b0 : (rd || (m_busy && !dma_stopped));
            m_cad  = rs;
            if (clr) begin
                m_hold = 0; m_en = 0; m_len = 0;
            end else begin
                if (cw) begin m_hold = wr_data[5]; m_en = wr_data[4:2]; end
                if (lw) m_len = wr_data;
            end
            m_run = rd;
            // reset sequence
            case (m_state)
                0: begin m_cnt = 0; if (start) m_state = 1; end
                1: begin if (m_cnt == 3) begin m_state = 2; m_cnt = 0; end else m_cnt++; end
                2: begin m_cnt = 0; if (cw && !wr_data[0]) m_state = 3; end
                default: begin if (m_cnt == 3) begin m_state = 0; m_cnt = 0; end else m_cnt++; end
            endcase
        end
    end

    function automatic logic [31:0] m_read(input int a);
        case (a)
            0: return {26'b0, m_hold, m_en, m_busy, (m_state == 2 || m_state == 3)};
            1: return {26'b0, m_st, 2'b00};
            2: return m_pos;
            default: return m_len;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        for (int a = 0; a < 4; a++) begin
            rd_addr = 2'(a);
            #1;
            case (a)
                0: chk("R2 R3 R4 R6 control", rd_data, m_read(a));
                1: chk("R8 status", rd_data, m_read(a));
                2: chk("R10 position", rd_data, m_read(a));
                default: chk("R2 length", rd_data, m_read(a));
            endcase
        end
        chk("R5 dma_en", {31'b0, dma_en}, {31'b0, m_run && !m_hold && m_state == 0});
        chk("R7 cad_rst", {31'b0, cad_rst}, {31'b0, m_cad});
        chk("R2 fifo_flush", {31'b0, fifo_flush}, {31'b0, m_state != 0});
        chk("R9 irq", {31'b0, irq}, {31'b0, |(m_st[2:0] & m_en)});
    endtask

    task automatic tick();
        @(negedge clk);
        compare_all();
        wr_en = 0; ev_ioc = 0; ev_underrun = 0; ev_desc_err = 0; bytes_valid = 0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        tick();
    endtask

    task automatic send(input int n);
        bytes_valid = 1; bytes = 16'(n);
        tick();
    endtask

    task automatic check_reg(input logic [1:0] a, input logic [31:0] exp, input string tag);
        rd_addr = a;
        #1;
        chk(tag, rd_data, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        check_reg(2'd0, 0, "R1 control");
        check_reg(2'd1, 0, "R1 status");
        check_reg(2'd2, 0, "R1 position");
        check_reg(2'd3, 0, "R1 length");
        chk("R1 outputs", {28'b0, irq, dma_en, cad_rst, fifo_flush}, 0);

        wr(2'd3, 100);
        wr(2'd0, 32'h1E);                       // run + all enables
        chk("R7 cad pulse", {31'b0, cad_rst}, 1);
        check_reg(2'd0, 32'h1E, "R6 run reads 1");
        tick();
        chk("R7 cad one cycle", {31'b0, cad_rst}, 0);
        chk("R5 dma_en on", {31'b0, dma_en}, 1);

        repeat (4) send(30);                    // 30,60,90,20
        check_reg(2'd2, 20, "R10 wrap");

        wr(2'd0, 32'h3E);                       // hold
        chk("R5 hold blocks", {31'b0, dma_en}, 0);
        send(10);
        check_reg(2'd2, 20, "R10 no advance on hold");
        wr(2'd0, 32'h1E);

        ev_ioc = 1; tick();
        check_reg(2'd1, 32'h04, "R8 completion flag");
        chk("R9 irq enabled", {31'b0, irq}, 1);
        wr(2'd1, 32'h04);
        check_reg(2'd1, 0, "R8 w1c");
        ev_ioc = 1; wr(2'd1, 32'h04);           // set wins over clear
        check_reg(2'd1, 32'h04, "R8 set wins");
        wr(2'd1, 32'h04);

        wr(2'd0, 32'h16);                       // underrun enable off
        ev_underrun = 1; tick();
        check_reg(2'd1, 32'h08, "R8 underrun flag");
        chk("R9 gated off", {31'b0, irq}, 0);
        wr(2'd1, 32'h08);

        wr(2'd0, 32'h17);                       // reset while running
        check_reg(2'd1, 32'h20, "R4 refusal flag");
        check_reg(2'd0, 32'h16, "R4 no reset");
        chk("R9 flag no irq", {31'b0, irq}, 0);
        repeat (5) tick();
        check_reg(2'd0, 32'h16, "R4 still out of reset");
        wr(2'd1, 32'h20);

        dma_stopped = 0;
        wr(2'd0, 32'h14);                       // withdraw run
        check_reg(2'd0, 32'h16, "R6 busy lingers");
        repeat (5) tick();
        check_reg(2'd0, 32'h16, "R6 waits for idle");
        dma_stopped = 1; tick();
        check_reg(2'd0, 32'h14, "R6 drops on idle");

        ev_desc_err = 1; tick();
        chk("R9 desc irq", {31'b0, irq}, 1);

        wr(2'd0, 32'h01);                       // enter reset
        check_reg(2'd0, 0, "R2 cleared, bit0 0");
        check_reg(2'd1, 0, "R2 status cleared");
        check_reg(2'd3, 0, "R2 length cleared");
        chk("R2 flush", {31'b0, fifo_flush}, 1);
        for (int i = 0; i < 3; i++) begin
            tick();
            check_reg(2'd0, 0, "R2 bit0 still 0");
        end
        tick();
        check_reg(2'd0, 32'h01, "R2 bit0 reads 1");

        ev_ioc = 1; ev_desc_err = 1; tick();
        check_reg(2'd1, 0, "R3 events dropped in reset");
        wr(2'd0, 32'h3F);
        check_reg(2'd0, 32'h01, "R3 control writes ignored");
        wr(2'd3, 50);
        check_reg(2'd3, 0, "R3 length write ignored");

        wr(2'd0, 32'h00);                       // leave reset
        check_reg(2'd0, 32'h01, "R3 bit0 holds");
        for (int i = 0; i < 3; i++) begin
            tick();
            check_reg(2'd0, 32'h01, "R3 bit0 still 1");
        end
        tick();
        check_reg(2'd0, 0, "R3 bit0 reads 0");
        chk("R3 flush off", {31'b0, fifo_flush}, 0);

        wr(2'd0, 32'h02);                       // length 0
        send(40);
        check_reg(2'd2, 0, "R10 zero length");
        wr(2'd3, 64);
        send(40); send(30);
        check_reg(2'd2, 6, "R10 wrap 70-64");
        send(58);
        check_reg(2'd2, 0, "R10 exact length folds to 0");
        send(9);
        wr(2'd0, 32'h00);
        send(10);
        check_reg(2'd2, 9, "R10 stopped holds");
        wr(2'd0, 32'h02);
        check_reg(2'd2, 0, "R7 restart clears position");
        repeat (2) tick();

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule